// File: doc/BRIEF.md
# Parallel flash command sequencer

This block sits on the write side of a parallel NOR flash model or controller. It watches bus write cycles and decodes the two-cycle unlock command protocol. Each write carries a byte address and a data byte. The address is first reduced to a device word address according to the configured bus width. The sequencer then tracks how far a command has progressed and which command is in force.

It reports the active mode, which can be read array, identifier readout, query table, program data entry, chip erase or sector erase. It raises single-cycle program and erase requests that carry the address and data. It also holds a flag while the shortened unlock-bypass command form is enabled.

The storage array, the status word and the erase timing all belong to neighbouring logic. That logic acts on the requests and signals the end of an erase through `erase_done_i`.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, `mode_o` is 0 (read array), `bypass_o` is 0 and no request output is high.
- R2: The word address is the byte address shifted right by 0, 1 or 2 for `width_i` = 0 (8-bit), 1 (16-bit) or 2 and 3 (32-bit). Only its low 11 bits are compared with `unlock0_i`, `unlock1_i` and the query word address 0x55.
- R3: An unlock takes two writes: 0xAA to `unlock0_i`, then 0x55 to `unlock1_i`. A wrong value or wrong address at either step returns to read array, and the unlock must start again.
- R4: The third write must go to `unlock0_i` unless bypass is set. Its value selects the command: 0xA0 program, 0x90 identifier readout (`mode_o` 1), 0x80 erase setup, 0x20 enable bypass. Any other value returns to read array.
- R5: After 0xA0, `mode_o` is 3 and the next write is program data. One cycle after that write edge, `prog_req_o` is high for exactly one cycle, `req_addr_o` holds the byte address and `req_data_o` holds the data. The mode then returns to 0.
- R6: Erase setup needs a second 0xAA/0x55 unlock. A following 0x10 written to `unlock0_i` raises `chip_erase_req_o` and sets `mode_o` to 4. A 0x10 written to any other address returns to read array.
- R7: In the same step, 0x30 written to any address raises `sector_erase_req_o` with that byte address and sets `mode_o` to 5.
- R8: While `mode_o` is 4 or 5, all writes are ignored, including 0xF0. A pulse on `erase_done_i` ends the erase. The decoder goes to read array, or to the bypass command stage when bypass is set.
- R9: From read array, 0x98 written to word 0x55 sets `mode_o` to 2 (query). Any write there, 0xF0 included, returns to read array.
- R10: From identifier readout, 0x98 written to word 0x55 sets `mode_o` to 2 as a nested query. In that nested query, 0xF0 returns to `mode_o` 1, and any other write returns to read array.
- R11: Outside program data entry and erase, 0xF0 returns to read array and clears bypass. In program data entry, 0xF0 is taken as program data.
- R12: With bypass set, a command write at any address is accepted without an unlock. After each program data write the decoder re-arms at the command stage with bypass still set. A 0x00 written in identifier readout clears bypass and returns to read array.
- R13: At most one of the three request outputs is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write cycle strobe, one write per cycle |
| addr_i | input | ADDR_W | Byte address of the write |
| data_i | input | 8 | Data byte of the write |
| width_i | input | 2 | Bus width: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| unlock0_i | input | 11 | First unlock word address |
| unlock1_i | input | 11 | Second unlock word address |
| erase_done_i | input | 1 | Erase completion pulse from timing logic |
| mode_o | output | 3 | Active mode: 0 read, 1 identifier, 2 query, 3 program, 4 chip erase, 5 sector erase |
| bypass_o | output | 1 | Unlock bypass enabled |
| prog_req_o | output | 1 | Program request pulse |
| chip_erase_req_o | output | 1 | Chip erase request pulse |
| sector_erase_req_o | output | 1 | Sector erase request pulse |
| req_addr_o | output | ADDR_W | Byte address for the request |
| req_data_o | output | 8 | Data byte for the request |

## Verification
Most wrong internal states do not show on `mode_o` at once. The unlock and erase-setup stages all report read array, so a decoder stuck in the wrong stage shows up only at a later write. That write is a command or data write that should produce a request pulse and either produces none, or produces one where none was expected. The bench therefore follows every rejected sequence with a write that would program if the state were wrong, and it checks every request pulse and its address and data one cycle after the write edge.

Mode faults, such as a nested query returning to the wrong mode or an erase that lets 0xF0 through, appear on `mode_o` right after the offending write edge. A wrong bypass flag appears either directly on `bypass_o` or as an extra or missing program request on the next data write.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  localparam int unsigned CMP_W = 11;

  localparam logic [7:0] CMD_UNLK_A  = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B  = 8'h55;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_PROG    = 8'hA0;
  localparam logic [7:0] CMD_BYPASS  = 8'h20;
  localparam logic [7:0] CMD_CHIP    = 8'h10;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_QUERY   = 8'h98;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [7:0] CMD_BYP_END = 8'h00;

  localparam logic [CMP_W-1:0] QUERY_WADDR = 11'h055;

  typedef enum logic [2:0] {
    MODE_READ     = 3'd0,
    MODE_IDENT    = 3'd1,
    MODE_QUERY    = 3'd2,
    MODE_PROG     = 3'd3,
    MODE_CHIP_ERS = 3'd4,
    MODE_SEC_ERS  = 3'd5
  } mode_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLK1,
    ST_CMD,
    ST_PROG_DATA,
    ST_ERS_UNLK0,
    ST_ERS_UNLK1,
    ST_ERS_CMD,
    ST_IDENT,
    ST_QUERY,
    ST_QUERY_ID,
    ST_CHIP_ERS,
    ST_SEC_ERS
  } seq_state_e;

  function automatic mode_e mode_of(seq_state_e st);
    case (st)
      ST_IDENT:              mode_of = MODE_IDENT;
      ST_QUERY, ST_QUERY_ID: mode_of = MODE_QUERY;
      ST_PROG_DATA:          mode_of = MODE_PROG;
      ST_CHIP_ERS:           mode_of = MODE_CHIP_ERS;
      ST_SEC_ERS:            mode_of = MODE_SEC_ERS;
      default:               mode_of = MODE_READ;
    endcase
  endfunction

endpackage

// File: rtl/flash_addr_norm.sv
module flash_addr_norm
  import flash_seq_pkg::*;
#(
  parameter int unsigned OUT_W = CMP_W
) (
  input  logic [OUT_W+1:0] addr_i,
  input  logic [1:0]       width_i,
  output logic [OUT_W-1:0] word_o
);

  localparam int unsigned NUM_SH = 3;

  logic [OUT_W-1:0] cand [NUM_SH];

  for (genvar k = 0; k < NUM_SH; k++) begin : g_shift
    assign cand[k] = addr_i[k +: OUT_W];
  end

  always_comb begin
    case (width_i)
      2'd0:    word_o = cand[0];
      2'd1:    word_o = cand[1];
      default: word_o = cand[2];
    endcase
  end

endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [7:0]       data_i,
  input  logic [CMP_W-1:0] word_i,
  input  logic [CMP_W-1:0] unlock0_i,
  input  logic [CMP_W-1:0] unlock1_i,
  input  logic             erase_done_i,
  output seq_state_e       state_o,
  output logic             bypass_o,
  output logic             fire_prog_o,
  output logic             fire_chip_o,
  output logic             fire_sec_o
);

  seq_state_e state_q, state_d;
  logic       byp_q, byp_d;
  logic       erasing, go_idle;
  logic       at_u0, at_u1, at_query;

  assign erasing  = (state_q == ST_CHIP_ERS) || (state_q == ST_SEC_ERS);
  assign at_u0    = (word_i == unlock0_i);
  assign at_u1    = (word_i == unlock1_i);
  assign at_query = (word_i == QUERY_WADDR) && (data_i == CMD_QUERY);

  always_comb begin
    state_d     = state_q;
    byp_d       = byp_q;
    go_idle     = 1'b0;
    fire_prog_o = 1'b0;
    fire_chip_o = 1'b0;
    fire_sec_o  = 1'b0;
    if (erasing) begin
      if (erase_done_i) state_d = byp_q ? ST_CMD : ST_IDLE;
    end else if (wr_en_i) begin
      if (data_i == CMD_RESET && state_q != ST_PROG_DATA) begin
        if (state_q == ST_QUERY_ID) state_d = ST_IDENT;
        else                        go_idle = 1'b1;
      end else begin
        case (state_q)
          ST_IDLE: begin
            if (at_query)                          state_d = ST_QUERY;
            else if (at_u0 && data_i == CMD_UNLK_A) state_d = ST_UNLK1;
            else                                   go_idle = 1'b1;
          end
          ST_UNLK1, ST_ERS_UNLK1: begin
            if (at_u1 && data_i == CMD_UNLK_B)
              state_d = (state_q == ST_UNLK1) ? ST_CMD : ST_ERS_CMD;
            else go_idle = 1'b1;
          end
          ST_CMD: begin
            if (!byp_q && !at_u0) go_idle = 1'b1;
            else begin
              case (data_i)
                CMD_BYPASS: byp_d   = 1'b1;
                CMD_ERASE:  state_d = ST_ERS_UNLK0;
                CMD_IDENT:  state_d = ST_IDENT;
                CMD_PROG:   state_d = ST_PROG_DATA;
                default:    go_idle = 1'b1;
              endcase
            end
          end
          ST_PROG_DATA: begin
            fire_prog_o = 1'b1;
            state_d     = byp_q ? ST_CMD : ST_IDLE;
          end
          ST_ERS_UNLK0: begin
            if (at_u0 && data_i == CMD_UNLK_A) state_d = ST_ERS_UNLK1;
            else                               go_idle = 1'b1;
          end
          ST_ERS_CMD: begin
            if (data_i == CMD_CHIP && at_u0) begin
              fire_chip_o = 1'b1;
              state_d     = ST_CHIP_ERS;
            end else if (data_i == CMD_SECTOR) begin
              fire_sec_o = 1'b1;
              state_d    = ST_SEC_ERS;
            end else go_idle = 1'b1;
          end
          ST_IDENT: begin
            // bypass exit (0x00) and every other write both land in read array
            if (at_query) state_d = ST_QUERY_ID;
            else          go_idle = 1'b1;
          end
          default: go_idle = 1'b1;
        endcase
      end
    end
    if (go_idle) begin
      state_d = ST_IDLE;
      byp_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      byp_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byp_q   <= byp_d;
    end
  end

  assign state_o  = state_q;
  assign bypass_o = byp_q;

  // R13
  a_r13_one_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fire_prog_o, fire_chip_o, fire_sec_o}));

  // R8
  a_r8_erase_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (erasing && !erase_done_i) |=> (state_q == $past(state_q)));

  // R12
  a_r12_bypass_at_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byp_q) |-> (state_q == ST_CMD));

  // R5
  a_r5_prog_one_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PROG_DATA && wr_en_i) |=> (state_q != ST_PROG_DATA));

endmodule

// File: rtl/flash_req_out.sv
module flash_req_out #(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_prog_i,
  input  logic              fire_chip_i,
  input  logic              fire_sec_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              prog_req_o,
  output logic              chip_req_o,
  output logic              sec_req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [7:0]        data_o
);

  logic any_fire;
  assign any_fire = fire_prog_i | fire_chip_i | fire_sec_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prog_req_o <= 1'b0;
      chip_req_o <= 1'b0;
      sec_req_o  <= 1'b0;
      addr_o     <= '0;
      data_o     <= '0;
    end else begin
      prog_req_o <= fire_prog_i;
      chip_req_o <= fire_chip_i;
      sec_req_o  <= fire_sec_i;
      if (any_fire) begin
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end
  end

  // R5
  a_r5_prog_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |=> !prog_req_o);

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_seq_pkg::*;
#(
  parameter int unsigned ADDR_W = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic [1:0]        width_i,
  input  logic [10:0]       unlock0_i,
  input  logic [10:0]       unlock1_i,
  input  logic              erase_done_i,
  output logic [2:0]        mode_o,
  output logic              bypass_o,
  output logic              prog_req_o,
  output logic              chip_erase_req_o,
  output logic              sector_erase_req_o,
  output logic [ADDR_W-1:0] req_addr_o,
  output logic [7:0]        req_data_o
);

  localparam int unsigned NORM_IN_W = CMP_W + 2;

  logic [CMP_W-1:0] word;
  seq_state_e       state;
  logic             fire_prog, fire_chip, fire_sec;

  flash_addr_norm #(.OUT_W(CMP_W)) u_norm (
    .addr_i  (addr_i[NORM_IN_W-1:0]),
    .width_i (width_i),
    .word_o  (word)
  );

  flash_seq_fsm u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .data_i       (data_i),
    .word_i       (word),
    .unlock0_i    (unlock0_i),
    .unlock1_i    (unlock1_i),
    .erase_done_i (erase_done_i),
    .state_o      (state),
    .bypass_o     (bypass_o),
    .fire_prog_o  (fire_prog),
    .fire_chip_o  (fire_chip),
    .fire_sec_o   (fire_sec)
  );

  flash_req_out #(.ADDR_W(ADDR_W)) u_req (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fire_prog_i (fire_prog),
    .fire_chip_i (fire_chip),
    .fire_sec_i  (fire_sec),
    .addr_i      (addr_i),
    .data_i      (data_i),
    .prog_req_o  (prog_req_o),
    .chip_req_o  (chip_erase_req_o),
    .sec_req_o   (sector_erase_req_o),
    .addr_o      (req_addr_o),
    .data_o      (req_data_o)
  );

  assign mode_o = mode_of(state);

  // R5
  a_r5_prog_from_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_req_o |-> ($past(mode_o) == MODE_PROG));

  // R6
  a_r6_chip_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chip_erase_req_o |-> (mode_o == MODE_CHIP_ERS));

  // R7
  a_r7_sector_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sector_erase_req_o |-> (mode_o == MODE_SEC_ERS));

endmodule

// File: tb/flash_cmd_seq_bench.sv
`timescale 1ns/100ps
module flash_cmd_seq_bench;

  localparam int unsigned AW = 24;
  localparam logic [10:0] U0 = 11'h555;
  localparam logic [10:0] U1 = 11'h2AA;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    data = '0;
  logic [1:0]    width = 2'd0;
  logic          done = 1'b0;
  logic [2:0]    mode;
  logic          byp, preq, creq, sreq;
  logic [AW-1:0] raddr;
  logic [7:0]    rdata;

  int checks = 0;
  int errors = 0;
  int sh = 0;

  typedef struct packed {
    logic [1:0]    kind;   // 0 program, 1 chip erase, 2 sector erase
    logic [AW-1:0] a;
    logic [7:0]    d;
    logic [3:0]    rid;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW)) u_flash_cmd_seq (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .width_i(width), .unlock0_i(U0), .unlock1_i(U1), .erase_done_i(done),
    .mode_o(mode), .bypass_o(byp), .prog_req_o(preq), .chip_erase_req_o(creq),
    .sector_erase_req_o(sreq), .req_addr_o(raddr), .req_data_o(rdata)
  );

  // monitor: every request pulse must match the head of the queue
  always @(negedge clk) begin
    if (rst_n && (preq || creq || sreq)) begin
      exp_t e;
      logic [1:0] k;
      checks++;
      k = creq ? 2'd1 : (sreq ? 2'd2 : 2'd0);
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R13 unexpected request kind=%0d addr=%h data=%h expected none", k, raddr, rdata);
      end else begin
        e = exp_q.pop_front();
        if ((preq + creq + sreq) != 1 || k != e.kind || raddr != e.a || rdata != e.d) begin
          errors++;
          $display("FAIL R%0d request kind=%0d addr=%h data=%h expected kind=%0d addr=%h data=%h",
                   e.rid, k, raddr, rdata, e.kind, e.a, e.d);
        end
      end
    end
  end

  task automatic wr_b(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr_w(input logic [AW-1:0] w, input logic [7:0] d);
    wr_b(w << sh, d);
  endtask

  task automatic unlock();
    wr_w({13'd0, U0}, 8'hAA);
    wr_w({13'd0, U1}, 8'h55);
  endtask

  task automatic push(input logic [1:0] k, input logic [AW-1:0] a, input logic [7:0] d,
                      input logic [3:0] rid);
    exp_q.push_back({k, a, d, rid});
  endtask

  task automatic chk(input logic [2:0] em, input logic eb, input string tag);
    checks++;
    if (mode !== em || byp !== eb) begin
      errors++;
      $display("FAIL %s mode=%0d bypass=%0d expected mode=%0d bypass=%0d", tag, mode, byp, em, eb);
    end
  endtask

  task automatic erase_done();
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (mode !== 3'd0 || byp !== 1'b0 || preq || creq || sreq) begin
      errors++;
      $display("FAIL R1 reset mode=%0d bypass=%0d req=%b expected 0 0 000", mode, byp, {preq, creq, sreq});
    end

    // R5 basic program at 8-bit width
    unlock(); wr_w({13'd0, U0}, 8'hA0);
    chk(3'd3, 1'b0, "R5 program entry");
    push(2'd0, 24'h001234, 8'h3C, 4'd5);
    wr_b(24'h001234, 8'h3C);
    chk(3'd0, 1'b0, "R5 back to read");

    // R3 bad second unlock, then stray writes must not program
    wr_w({13'd0, U0}, 8'hAA); wr_w(24'h0002AB, 8'h55);
    wr_w({13'd0, U0}, 8'hA0); wr_b(24'h000040, 8'h11);
    chk(3'd0, 1'b0, "R3 bad unlock");

    // R4 bad command value and bad command address
    unlock(); wr_w({13'd0, U0}, 8'h77);
    chk(3'd0, 1'b0, "R4 bad command");
    wr_b(24'h000050, 8'h22);
    unlock(); wr_w(24'h000554, 8'hA0);
    chk(3'd0, 1'b0, "R4 wrong command address");

    // R2 16-bit: byte address 0x555 maps to word 0x2AA, no unlock
    width = 2'd1;
    wr_b(24'h000555, 8'hAA); wr_b(24'h000554, 8'h55); wr_b(24'h000AAA, 8'hA0);
    chk(3'd0, 1'b0, "R2 16-bit misaligned unlock");
    sh = 1;
    unlock(); wr_w({13'd0, U0}, 8'hA0);
    chk(3'd3, 1'b0, "R2 16-bit unlock");
    push(2'd0, 24'h00ABCE, 8'h81, 4'd2);
    wr_b(24'h00ABCE, 8'h81);

    // R2 32-bit: bits above the low 11 word bits are ignored
    width = 2'd2; sh = 2;
    wr_b(24'h103554, 8'hAA); wr_w({13'd0, U1}, 8'h55); wr_w({13'd0, U0}, 8'hA0);
    chk(3'd3, 1'b0, "R2 32-bit upper bits ignored");
    push(2'd0, 24'h004444, 8'h0F, 4'd2);
    wr_b(24'h004444, 8'h0F);
    width = 2'd0; sh = 0;

    // R10 nested query under identifier readout
    unlock(); wr_w({13'd0, U0}, 8'h90);
    chk(3'd1, 1'b0, "R4 identifier entry");
    wr_w(24'h000055, 8'h98);
    chk(3'd2, 1'b0, "R10 nested query entry");
    wr_b(24'h000000, 8'hF0);
    chk(3'd1, 1'b0, "R10 reset returns to identifier");
    wr_w(24'h000055, 8'h98); wr_b(24'h000010, 8'h12);
    chk(3'd0, 1'b0, "R10 other write leaves to read");

    // R9 query from read
    wr_w(24'h000055, 8'h98);
    chk(3'd2, 1'b0, "R9 query entry");
    wr_b(24'h000000, 8'hF0);
    chk(3'd0, 1'b0, "R9 reset from query");
    wr_w(24'h000055, 8'h98); wr_b(24'h000020, 8'h33);
    chk(3'd0, 1'b0, "R9 other write from query");

    // R6 chip erase; R8 writes ignored until done
    unlock(); wr_w({13'd0, U0}, 8'h80); unlock();
    push(2'd1, {13'd0, U0}, 8'h10, 4'd6);
    wr_w({13'd0, U0}, 8'h10);
    chk(3'd4, 1'b0, "R6 chip erase mode");
    wr_b(24'h000000, 8'hF0);
    chk(3'd4, 1'b0, "R8 reset ignored in chip erase");
    erase_done();
    chk(3'd0, 1'b0, "R8 chip erase done");

    // R7 sector erase
    unlock(); wr_w({13'd0, U0}, 8'h80); unlock();
    push(2'd2, 24'h008000, 8'h30, 4'd7);
    wr_b(24'h008000, 8'h30);
    chk(3'd5, 1'b0, "R7 sector erase mode");
    wr_b(24'h00C000, 8'h30);
    chk(3'd5, 1'b0, "R8 write ignored in sector erase");
    erase_done();
    chk(3'd0, 1'b0, "R8 sector erase done");

    // R6 chip erase code at wrong address
    unlock(); wr_w({13'd0, U0}, 8'h80); unlock(); wr_w(24'h000100, 8'h10);
    chk(3'd0, 1'b0, "R6 chip erase wrong address");

    // R11 reset mid-unlock, and 0xF0 as program data
    unlock(); wr_b(24'h000000, 8'hF0); wr_w({13'd0, U0}, 8'hA0);
    chk(3'd0, 1'b0, "R11 reset mid unlock");
    unlock(); wr_w({13'd0, U0}, 8'hA0);
    push(2'd0, 24'h000100, 8'hF0, 4'd11);
    wr_b(24'h000100, 8'hF0);

    // R12 bypass
    unlock(); wr_w({13'd0, U0}, 8'h20);
    chk(3'd0, 1'b1, "R12 bypass entry");
    wr_b(24'h000999, 8'hA0);
    chk(3'd3, 1'b1, "R12 program without unlock");
    push(2'd0, 24'h002000, 8'h5A, 4'd12);
    wr_b(24'h002000, 8'h5A);
    chk(3'd0, 1'b1, "R12 re-armed after program");
    wr_b(24'h000000, 8'hA0);
    push(2'd0, 24'h002001, 8'hA5, 4'd12);
    wr_b(24'h002001, 8'hA5);
    wr_b(24'h000000, 8'h90);
    chk(3'd1, 1'b1, "R12 identifier under bypass");
    wr_b(24'h000000, 8'h00);
    chk(3'd0, 1'b0, "R12 bypass exit");

    // R8 erase under bypass returns to bypass stage; R11 then clears bypass
    unlock(); wr_w({13'd0, U0}, 8'h20);
    wr_b(24'h000000, 8'h80); unlock();
    push(2'd2, 24'h010000, 8'h30, 4'd7);
    wr_b(24'h010000, 8'h30);
    erase_done();
    chk(3'd0, 1'b1, "R8 erase done keeps bypass");
    wr_b(24'h000000, 8'hF0);
    chk(3'd0, 1'b0, "R11 reset clears bypass");
    wr_b(24'h000000, 8'hA0);
    chk(3'd0, 1'b0, "R11 no program after bypass cleared");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R13 missing requests count=%0d expected 0", exp_q.size());
    end
    summary();
  end

endmodule